// File: doc/BRIEF.md
# Buffered Dual-Compare PWM Channel

This block is a single pulse-width-modulated output channel. It has no counter of its own. A shared time base drives a counter bus, and an update strobe qualifies each new bus value. On every strobe the channel compares the bus value with a leading-edge compare value and a trailing-edge compare value. A leading-edge equality makes the output active. A trailing-edge equality makes it inactive, and when both compares are equal in the same strobe the trailing-edge result wins.

Both compare values are double-buffered. Software writes land in a staging register. The staging content moves into the working register only on the strobe where the counter bus holds its minimum value, which is the start of a period. The comparison on that same strobe already uses the newly moved values. A polarity input selects the active level. A disable input forces the pin to its inactive level at once and leaves the internal state untouched. A sticky event flag records trailing-edge matches, and an interrupt request is derived from that flag. Full-on and full-off outputs come only from the choice of compare values.

Top module: `pwm_dual_cmp`

## Requirements
- R1: After reset the internal output state is inactive, so `pwmOut` equals `!polarity`, and both `flag` and `irq` are 0.
- R2: On a strobe where the counter bus equals the working leading compare and does not equal the working trailing compare, the output becomes active (`pwmOut == polarity`) from the next clock.
- R3: On a strobe where the counter bus equals the working trailing compare, the output becomes inactive from the next clock, even if the leading compare also matches.
- R4: Writes through `wrLead`/`wrTrail` do not change the waveform until a strobe with `cntBus == CNT_MIN`. On that strobe the staged values become the working values and are also used for that strobe's comparison.
- R5: On cycles with `cntStrobe` low, no comparison takes place and the output state holds.
- R6: `outDisable` high forces `pwmOut` to `!polarity` in the same cycle. When it is released, the level held by the internal state reappears.
- R7: `flag` is set on the clock after a trailing-edge match and stays set until a clock with `flagClr` high. If a match and a clear arrive together, the flag stays set.
- R8: `irq` equals `flag` AND `irqEn`.
- R9: A trailing compare the counter never reaches gives a continuously active output once the leading match has occurred. A leading compare the counter never reaches, together with an in-range trailing compare, gives a continuously inactive output.
- R10: `polarity` selects the active level combinationally: `pwmOut` = internal state XOR `!polarity` (active state gives `pwmOut == polarity`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cntBus | input | CNT_W | Counter value from the shared time base |
| cntStrobe | input | 1 | Qualifies a new counter bus value |
| wrLead | input | 1 | Write `wrData` into the leading-compare staging register |
| wrTrail | input | 1 | Write `wrData` into the trailing-compare staging register |
| wrData | input | CNT_W | Write data for the staging registers |
| polarity | input | 1 | Active output level |
| outDisable | input | 1 | Forces the output to its inactive level |
| flagClr | input | 1 | Clears the event flag (write-one-to-clear) |
| irqEn | input | 1 | Interrupt enable |
| pwmOut | output | 1 | PWM output pin |
| flag | output | 1 | Sticky trailing-match flag |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted working compare value appears at the pin as an edge at the wrong counter value, and it can show up as late as one full period after the write that caused it. Loading the working registers too early moves an edge inside the current period, and this is visible on the next strobe after the write. A wrong precedence or a wrong output-state bit changes `pwmOut` on the clock right after the strobe involved. The disable and polarity paths are combinational, so any error in them shows within the same cycle.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic xfer;    // move staging into working this cycle
    logic ldLead;  // capture write data into leading staging
    logic ldTrail; // capture write data into trailing staging
  } ctlStrobeT;
endpackage

// File: rtl/pwm_cmp_dp.sv
module pwm_cmp_dp
  import pwm_pkg::*;
#(
  parameter int CNT_W   = 24,
  parameter int CNT_MIN = 0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] cntBus,
  input  logic             cntStrobe,
  input  logic [CNT_W-1:0] wrData,
  input  ctlStrobeT        ctl,
  output logic             atMin,
  output logic             matchLead,
  output logic             matchTrail
);
  localparam logic [CNT_W-1:0] MinVal = CNT_W'(CNT_MIN);
  localparam int NumCmp = 2;

  logic [CNT_W-1:0] stageQ [NumCmp];
  logic [CNT_W-1:0] workQ  [NumCmp];
  logic [NumCmp-1:0] ldVec;
  logic [NumCmp-1:0] eqVec;

  assign ldVec = {ctl.ldTrail, ctl.ldLead};
  assign atMin = (cntBus == MinVal);

  for (genvar i = 0; i < NumCmp; i++) begin : gCmp
    logic [CNT_W-1:0] effVal;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stageQ[i] <= '0;
        workQ[i]  <= '0;
      end else begin
        if (ldVec[i])  stageQ[i] <= wrData;
        if (ctl.xfer)  workQ[i]  <= stageQ[i];
      end
    end

    // the start-of-period strobe compares against the values being loaded
    assign effVal   = ctl.xfer ? stageQ[i] : workQ[i];
    assign eqVec[i] = cntStrobe && (cntBus == effVal);
  end

  assign matchLead  = eqVec[0];
  assign matchTrail = eqVec[1];

  AST_WORK_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.xfer |=> ($stable(workQ[0]) && $stable(workQ[1]))) else $error("working value changed off boundary"); // R4
  AST_NO_MATCH_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !cntStrobe |-> !(matchLead || matchTrail)) else $error("match without strobe"); // R5
endmodule

// File: rtl/pwm_cmp_ctl.sv
module pwm_cmp_ctl
  import pwm_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cntStrobe,
  input  logic      atMin,
  input  logic      matchLead,
  input  logic      matchTrail,
  input  logic      wrLead,
  input  logic      wrTrail,
  input  logic      flagClr,
  input  logic      irqEn,
  input  logic      polarity,
  input  logic      outDisable,
  output ctlStrobeT ctl,
  output logic      pwmOut,
  output logic      flag,
  output logic      irq
);
  logic activeQ;
  logic flagQ;

  always_comb begin
    ctl.xfer    = cntStrobe && atMin;
    ctl.ldLead  = wrLead;
    ctl.ldTrail = wrTrail;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      flagQ   <= 1'b0;
    end else begin
      if (matchTrail)     activeQ <= 1'b0;
      else if (matchLead) activeQ <= 1'b1;
      if (matchTrail)     flagQ <= 1'b1;
      else if (flagClr)   flagQ <= 1'b0;
    end
  end

  assign pwmOut = (activeQ && !outDisable) ? polarity : !polarity;
  assign flag   = flagQ;
  assign irq    = flagQ && irqEn;

  AST_TRAIL_WINS: assert property (@(posedge clk) disable iff (!rstN)
    matchTrail |=> !activeQ) else $error("trailing match did not deactivate"); // R3
  AST_LEAD_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (matchLead && !matchTrail) |=> activeQ) else $error("leading match did not activate"); // R2
  AST_STATE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !cntStrobe |=> $stable(activeQ)) else $error("state moved without strobe"); // R5
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rstN)
    matchTrail |=> flagQ) else $error("flag missed trailing match"); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (flagQ && !flagClr) |=> flagQ) else $error("flag dropped without clear"); // R7
endmodule

// File: rtl/pwm_dual_cmp.sv
module pwm_dual_cmp
  import pwm_pkg::*;
#(
  parameter int CNT_W   = 24,
  parameter int CNT_MIN = 0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] cntBus,
  input  logic             cntStrobe,
  input  logic             wrLead,
  input  logic             wrTrail,
  input  logic [CNT_W-1:0] wrData,
  input  logic             polarity,
  input  logic             outDisable,
  input  logic             flagClr,
  input  logic             irqEn,
  output logic             pwmOut,
  output logic             flag,
  output logic             irq
);
  ctlStrobeT ctl;
  logic atMin, matchLead, matchTrail;

  pwm_cmp_dp #(.CNT_W(CNT_W), .CNT_MIN(CNT_MIN)) uDp (
    .clk(clk), .rstN(rstN), .cntBus(cntBus), .cntStrobe(cntStrobe),
    .wrData(wrData), .ctl(ctl), .atMin(atMin),
    .matchLead(matchLead), .matchTrail(matchTrail)
  );

  pwm_cmp_ctl uCtl (
    .clk(clk), .rstN(rstN), .cntStrobe(cntStrobe), .atMin(atMin),
    .matchLead(matchLead), .matchTrail(matchTrail),
    .wrLead(wrLead), .wrTrail(wrTrail), .flagClr(flagClr), .irqEn(irqEn),
    .polarity(polarity), .outDisable(outDisable),
    .ctl(ctl), .pwmOut(pwmOut), .flag(flag), .irq(irq)
  );

  AST_DISABLE_FORCES: assert property (@(posedge clk) disable iff (!rstN)
    outDisable |-> (pwmOut == !polarity)) else $error("disable not honoured"); // R6
endmodule

// File: tb/pwm_dual_cmp_test.sv
`timescale 1ns/1ps
module pwm_dual_cmp_test;
  localparam int CW = 24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [CW-1:0] cntBus = '0;
  logic cntStrobe = 1'b0, wrLead = 1'b0, wrTrail = 1'b0;
  logic [CW-1:0] wrData = '0;
  logic polarity = 1'b1, outDisable = 1'b0, flagClr = 1'b0, irqEn = 1'b0;
  logic pwmOut, flag, irq;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pwm_dual_cmp #(.CNT_W(CW)) uut (
    .clk(clk), .rstN(rstN), .cntBus(cntBus), .cntStrobe(cntStrobe),
    .wrLead(wrLead), .wrTrail(wrTrail), .wrData(wrData),
    .polarity(polarity), .outDisable(outDisable), .flagClr(flagClr),
    .irqEn(irqEn), .pwmOut(pwmOut), .flag(flag), .irq(irq)
  );

  typedef struct packed {
    logic [7:0] cnt;
    logic       stb;
    logic       expOut;
    logic       expFlag;
  } vecT;

  // leading=2, trailing=6, polarity=1, counter 0..8
  localparam int NV = 11;
  localparam vecT VEC [NV] = '{
    '{8'd0, 1'b1, 1'b0, 1'b0},   // R4 load at minimum
    '{8'd1, 1'b1, 1'b0, 1'b0},
    '{8'd2, 1'b1, 1'b1, 1'b0},   // R2
    '{8'd6, 1'b0, 1'b1, 1'b0},   // R5 no strobe
    '{8'd3, 1'b1, 1'b1, 1'b0},
    '{8'd6, 1'b1, 1'b0, 1'b1},   // R3 R7
    '{8'd7, 1'b1, 1'b0, 1'b1},
    '{8'd8, 1'b1, 1'b0, 1'b1},
    '{8'd0, 1'b1, 1'b0, 1'b1},
    '{8'd2, 1'b1, 1'b1, 1'b1},
    '{8'd6, 1'b1, 1'b0, 1'b1}
  };

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic tick(input int c, input logic s, input logic clr);
    @(negedge clk);
    cntBus = CW'(c);
    cntStrobe = s;
    flagClr = clr;
    @(posedge clk);
    #1;
    cntStrobe = 1'b0;
    flagClr = 1'b0;
  endtask

  task automatic stage(input logic trail, input int v);
    @(negedge clk);
    wrData = CW'(v);
    wrLead = !trail;
    wrTrail = trail;
    @(posedge clk);
    #1;
    wrLead = 1'b0;
    wrTrail = 1'b0;
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(pwmOut, 1'b0, "R1 out");
    check(flag, 1'b0, "R1 flag");
    check(irq, 1'b0, "R1 irq");
    @(negedge clk);
    rstN = 1'b1;

    stage(1'b0, 2);
    stage(1'b1, 6);
    for (int i = 0; i < NV; i++) begin
      tick(int'(VEC[i].cnt), VEC[i].stb, 1'b0);
      check(pwmOut, VEC[i].expOut, "R2/R3/R4/R5 table out");
      check(flag, VEC[i].expFlag, "R7 table flag");
    end

    // R8 irq gating
    irqEn = 1'b0; #1; check(irq, 1'b0, "R8 disabled");
    irqEn = 1'b1; #1; check(irq, 1'b1, "R8 enabled");
    // R7 clear, then set wins over clear
    tick(7, 1'b0, 1'b1);
    check(flag, 1'b0, "R7 clear");
    check(irq, 1'b0, "R8 follows flag");
    tick(6, 1'b1, 1'b1);
    check(flag, 1'b1, "R7 set beats clear");
    tick(7, 1'b0, 1'b1);

    // R4 staged write not used until wrap
    stage(1'b0, 4);
    tick(2, 1'b1, 1'b0); check(pwmOut, 1'b1, "R4 old leading still used");
    tick(6, 1'b1, 1'b0); check(pwmOut, 1'b0, "R4 trail");
    tick(0, 1'b1, 1'b0); check(pwmOut, 1'b0, "R4 wrap");
    tick(2, 1'b1, 1'b0); check(pwmOut, 1'b0, "R4 old leading gone");
    tick(4, 1'b1, 1'b0); check(pwmOut, 1'b1, "R4 new leading");

    // R9 full-on: trailing never reached
    stage(1'b1, 9);
    tick(6, 1'b1, 1'b0); check(pwmOut, 1'b0, "R4 trail still 6");
    tick(0, 1'b1, 1'b0);
    tick(4, 1'b1, 1'b0); check(pwmOut, 1'b1, "R9 full-on rise");
    tick(6, 1'b1, 1'b0); check(pwmOut, 1'b1, "R9 full-on 6");
    tick(8, 1'b1, 1'b0); check(pwmOut, 1'b1, "R9 full-on 8");
    tick(0, 1'b1, 1'b0); check(pwmOut, 1'b1, "R9 full-on wrap");

    // R3 equal compares: trailing wins while active
    stage(1'b0, 3);
    stage(1'b1, 3);
    tick(7, 1'b0, 1'b1);
    check(flag, 1'b0, "R7 cleared before precedence");
    tick(0, 1'b1, 1'b0); check(pwmOut, 1'b1, "R3 before match");
    tick(3, 1'b1, 1'b0); check(pwmOut, 1'b0, "R3 precedence");
    check(flag, 1'b1, "R7 precedence flag");

    // R9 full-off: leading never reached
    stage(1'b0, 9);
    tick(0, 1'b1, 1'b0);
    for (int c = 1; c <= 8; c++) tick(c, 1'b1, 1'b0);
    check(pwmOut, 1'b0, "R9 full-off");

    // R6 disable, R10 polarity
    stage(1'b0, 1);
    stage(1'b1, 9);
    tick(0, 1'b1, 1'b0);
    tick(1, 1'b1, 1'b0); check(pwmOut, 1'b1, "R2 active before disable");
    outDisable = 1'b1; #1; check(pwmOut, 1'b0, "R6 immediate");
    tick(2, 1'b1, 1'b0); check(pwmOut, 1'b0, "R6 held");
    outDisable = 1'b0; #1; check(pwmOut, 1'b1, "R6 release");
    polarity = 1'b0; #1; check(pwmOut, 1'b0, "R10 low-active");
    outDisable = 1'b1; #1; check(pwmOut, 1'b1, "R10 R6 inactive high");
    outDisable = 1'b0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule